// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block is the software-facing register bank of a stream-to-memory DMA engine. A simple 32-bit register bus reaches it through a byte address, a write enable with write data, and a read enable. Read data comes back one clock later. It decodes seven word-aligned registers. Between them they cover five access kinds: read-only, write-only, read/write, write-pulse, and read combined with write-pulse.

The block keeps sticky event flags that software clears by writing ones. It also keeps a per-flag enable mask and a level interrupt that follows the enabled flags. The DMA datapath receives from it the run enable and three buffer pointers (start, end and consumer position), each kept to `AW` bits. The datapath sends back the producer position and single-cycle event pulses. Each clearing write is also forwarded to the datapath as a one-cycle pulse.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, every output is zero: read data, interrupt, enable, the three pointer outputs and the clear pulse.
- R2: Registers sit at byte offsets 0x00 status, 0x04 mask, 0x08 config, 0x0C start pointer, 0x10 end pointer, 0x14 producer position, 0x18 consumer pointer. Status and mask bits are ordered: bit0 buffer chunk written, bit1 memory write error, bit2 start misaligned, bit3 end misaligned, bit4 consumer pointer misaligned.
- R3: A status bit becomes 1 on the clock edge where its event input is high. It stays 1 until a write to 0x00 carries a 1 in that bit position. Writing 0 there leaves the bit as it is.
- R4: When an event and a clearing write reach the same status bit in the same cycle, the bit stays 1.
- R5: The interrupt output is high exactly when some status bit and its mask bit are both 1. Clearing the mask bit of the only active source lowers the interrupt.
- R6: The mask (bits 4:0 at 0x04) and the enable (bit 0 at 0x08) read back what was written. All other bits of these registers read 0. The enable output equals the stored enable bit.
- R7: Each write to 0x00 drives the clear-pulse output, one clock after the write, with write data bits 4:0 for exactly one cycle. Otherwise the clear-pulse output is zero.
- R8: The start, end and consumer pointers store write data bits AW-1:0 and drive them on their outputs. A read of 0x0C, 0x10 or 0x18 returns 0.
- R9: A read of 0x14 returns the producer position input, zero-extended from AW bits. Writes to 0x14 change nothing.
- R10: Offsets above 0x18, and offsets whose two low bits are not zero, read as 0. Writes to them change nothing.
- R11: Read data updates on the clock edge where read enable is high and holds its value at all other times. A read in the same cycle as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | BUS_AW | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 5 | Single-cycle event pulses from the datapath |
| written_addr_i | input | AW | Producer position from the datapath |
| enable_o | output | 1 | Run enable to the datapath |
| start_addr_o | output | AW | Buffer start pointer |
| end_addr_o | output | AW | Buffer end pointer |
| read_addr_o | output | AW | Consumer pointer |
| status_clr_o | output | 5 | One-cycle copy of a status clearing write |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check these properties:
- A status bit only falls through a clearing write, and it never rises without an event.
- An event always lands in the status register.
- The interrupt is never high without a set status bit and a set mask bit.
- Pointers and read data move only when written or read.
- Every nonzero clear pulse comes from a status write.

The bench's reference model and directed scenarios cover what the assertions cannot:
- exact register decoding and read-back values;
- truncation of the pointers to AW bits;
- the interrupt falling when its mask bit is cleared;
- a simultaneous event and clear, where the event wins;
- writes to the read-only register and to unmapped or misaligned offsets having no effect.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_IRQ  = 5;
  localparam int NUM_REGS = 7;

  // word index of each register; byte offset = index * 4
  localparam int REG_STATUS  = 0;
  localparam int REG_MASK    = 1;
  localparam int REG_CONFIG  = 2;
  localparam int REG_START   = 3;
  localparam int REG_END     = 4;
  localparam int REG_WRITTEN = 5;
  localparam int REG_READ    = 6;

  // status / mask bit order
  localparam int IRQ_CHUNK_DONE = 0;
  localparam int IRQ_WR_ERR     = 1;
  localparam int IRQ_START_MIS  = 2;
  localparam int IRQ_END_MIS    = 3;
  localparam int IRQ_READ_MIS   = 4;

  localparam int NUM_PTRS = 3;

  function automatic int ptr_reg_idx(input int k);
    case (k)
      0:       return REG_START;
      1:       return REG_END;
      default: return REG_READ;
    endcase
  endfunction
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode #(
  parameter int BUS_AW   = 8,
  parameter int NUM_REGS = 7
) (
  input  logic [BUS_AW-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int WORD_W = BUS_AW - 2;

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = aligned && (addr_i[BUS_AW-1:2] == WORD_W'(g));
  end
endmodule

// File: rtl/dma_csr_field.sv
module dma_csr_field #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  // R8
  field_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/dma_csr_irq.sv
module dma_csr_irq #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] mask_q;

  // event has priority over a same-cycle clear
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       status_q[g] <= 1'b0;
      else if (evt_i[g]) status_q[g] <= 1'b1;
      else if (clr_i[g]) status_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign irq_o    = |(status_q & mask_q);
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_q) & ~$past(clr_i)) & ~status_q) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

  // R4
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> (($past(evt_i) & ~status_q) == '0));

  // R5
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != '0) && (mask_q != '0));
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int AW     = 20,
  parameter int BUS_AW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [BUS_AW-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_IRQ-1:0]   evt_i,
  input  logic [AW-1:0]        written_addr_i,
  output logic                 enable_o,
  output logic [AW-1:0]        start_addr_o,
  output logic [AW-1:0]        end_addr_o,
  output logic [AW-1:0]        read_addr_o,
  output logic [NUM_IRQ-1:0]   status_clr_o,
  output logic                 irq_o
);
  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic [NUM_IRQ-1:0]  clr_vec;
  logic [NUM_IRQ-1:0]  status;
  logic [NUM_IRQ-1:0]  mask;
  logic [AW-1:0]       ptr_q [NUM_PTRS];
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;
  logic [NUM_IRQ-1:0]  clr_q;

  dma_csr_decode #(.BUS_AW(BUS_AW), .NUM_REGS(NUM_REGS)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_sel  = sel & {NUM_REGS{wr_en_i}};
  assign clr_vec = wr_sel[REG_STATUS] ? wdata_i[NUM_IRQ-1:0] : '0;

  dma_csr_irq #(.N(NUM_IRQ)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .clr_i     (clr_vec),
    .mask_we_i (wr_sel[REG_MASK]),
    .mask_d_i  (wdata_i[NUM_IRQ-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  dma_csr_field #(.W(1)) u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_sel[REG_CONFIG]),
    .d_i    (wdata_i[0]),
    .q_o    (enable_o)
  );

  for (genvar k = 0; k < NUM_PTRS; k++) begin : g_ptr
    dma_csr_field #(.W(AW)) u_ptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_sel[ptr_reg_idx(k)]),
      .d_i    (wdata_i[AW-1:0]),
      .q_o    (ptr_q[k])
    );
  end

  assign start_addr_o = ptr_q[0];
  assign end_addr_o   = ptr_q[1];
  assign read_addr_o  = ptr_q[2];

  if (AW < DATA_W) begin : g_unused
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:AW];
  end

  // write-pulse side of the status register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= '0;
    else         clr_q <= clr_vec;
  end
  assign status_clr_o = clr_q;

  // write-only pointers and unmapped offsets fall through as zero
  always_comb begin
    rd_mux = '0;
    if (sel[REG_STATUS])  rd_mux = DATA_W'(status);
    if (sel[REG_MASK])    rd_mux = DATA_W'(mask);
    if (sel[REG_CONFIG])  rd_mux = DATA_W'(enable_o);
    if (sel[REG_WRITTEN]) rd_mux = DATA_W'(written_addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  // R7
  clr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_clr_o != '0) |-> $past(wr_en_i) && ($past(addr_i) == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_dma_csr_bank.sv
`timescale 1ns/1ps
module tb_dma_csr_bank;
  localparam int AW = 20;
  localparam int BAW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            wr_en_i = 1'b0;
  logic            rd_en_i = 1'b0;
  logic [BAW-1:0]  addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic [4:0]      evt_i = '0;
  logic [AW-1:0]   written_addr_i = '0;
  logic            enable_o;
  logic [AW-1:0]   start_addr_o, end_addr_o, read_addr_o;
  logic [4:0]      status_clr_o;
  logic            irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  dma_csr_bank #(.AW(AW), .BUS_AW(BAW)) dut (.*);

  always #2 clk_i = ~clk_i;

  // behavioural reference
  logic [4:0]    m_status = '0, m_mask = '0, m_clr = '0;
  logic          m_en = 1'b0;
  logic [AW-1:0] m_start = '0, m_end = '0, m_read = '0;
  logic [31:0]   m_rdata = '0;

  function automatic logic [31:0] model_read(input logic [BAW-1:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      8'h00:   return {27'h0, m_status};
      8'h04:   return {27'h0, m_mask};
      8'h08:   return {31'h0, m_en};
      8'h14:   return {{(32-AW){1'b0}}, written_addr_i};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_status = '0; m_mask = '0; m_clr = '0; m_en = 1'b0;
      m_start = '0; m_end = '0; m_read = '0; m_rdata = '0;
    end else begin
      if (rd_en_i) m_rdata = model_read(addr_i);
      m_clr = '0;
      if (wr_en_i) begin
        case (addr_i)
          8'h00: begin m_status = m_status & ~wdata_i[4:0]; m_clr = wdata_i[4:0]; end
          8'h04: m_mask  = wdata_i[4:0];
          8'h08: m_en    = wdata_i[0];
          8'h0C: m_start = wdata_i[AW-1:0];
          8'h10: m_end   = wdata_i[AW-1:0];
          8'h18: m_read  = wdata_i[AW-1:0];
          default: ;
        endcase
      end
      m_status = m_status | evt_i;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every cycle (all outputs registered or from registers)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R11 rdata", rdata_o, m_rdata);
      chk("R5 irq", {31'h0, irq_o}, {31'h0, |(m_status & m_mask)});
      chk("R6 enable", {31'h0, enable_o}, {31'h0, m_en});
      chk("R8 start", 32'(start_addr_o), 32'(m_start));
      chk("R8 end", 32'(end_addr_o), 32'(m_end));
      chk("R8 read", 32'(read_addr_o), 32'(m_read));
      chk("R7 clr", 32'(status_clr_o), 32'(m_clr));
    end
  end

  task automatic do_write(input logic [BAW-1:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [BAW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_en_i = 1'b0;
    chk(tag, rdata_o, exp);
  endtask

  task automatic pulse_evt(input logic [4:0] v);
    @(negedge clk_i); evt_i = v;
    @(negedge clk_i); evt_i = '0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 ptrs", 32'(start_addr_o | end_addr_o | read_addr_o), 32'h0);
    chk("R1 clr/en", {26'h0, status_clr_o, enable_o}, 32'h0);
    do_read(8'h00, 32'h0, "R1 status");
    do_read(8'h04, 32'h0, "R1 mask");

    // R8 pointers truncated and write-only
    do_write(8'h0C, 32'hABCDE040);
    chk("R8 start trunc", 32'(start_addr_o), 32'h000DE040);
    do_write(8'h10, 32'h12380000);
    chk("R8 end trunc", 32'(end_addr_o), 32'h00080000);
    do_write(8'h18, 32'hFFF00100);
    chk("R8 read ptr", 32'(read_addr_o), 32'h00000100);
    do_read(8'h0C, 32'h0, "R8 start wo");
    do_read(8'h18, 32'h0, "R8 read wo");

    // R9 producer position read-only
    written_addr_i = 20'hFACE0;
    do_read(8'h14, 32'h000FACE0, "R9 written rd");
    do_write(8'h14, 32'h11111111);
    do_read(8'h14, 32'h000FACE0, "R9 written ro");

    // R6 mask / config read-back width
    do_write(8'h04, 32'hFFFFFFFF);
    do_read(8'h04, 32'h0000001F, "R6 mask rb");
    do_write(8'h08, 32'hFFFFFFFE);
    chk("R6 enable low", {31'h0, enable_o}, 32'h0);
    do_write(8'h08, 32'hFFFFFFFF);
    do_read(8'h08, 32'h00000001, "R6 config rb");
    chk("R6 enable hi", {31'h0, enable_o}, 32'h1);

    // R2 R3 sticky event in bit2 (start misaligned)
    pulse_evt(5'b00100);
    chk("R5 irq set", {31'h0, irq_o}, 32'h1);
    do_read(8'h00, 32'h00000004, "R2 status bit2");
    do_write(8'h00, 32'h0);
    do_read(8'h00, 32'h00000004, "R3 write0 keeps");

    // R5 mask clear drops irq
    do_write(8'h04, 32'h0000001B);
    chk("R5 irq masked", {31'h0, irq_o}, 32'h0);
    do_write(8'h04, 32'h0000001F);
    chk("R5 irq back", {31'h0, irq_o}, 32'h1);

    // R7 clear pulse and W1C
    do_write(8'h00, 32'hFFFFFFE4);
    chk("R7 clr pulse", 32'(status_clr_o), 32'h4);
    @(negedge clk_i);
    chk("R7 clr one cycle", 32'(status_clr_o), 32'h0);
    do_read(8'h00, 32'h0, "R3 cleared");

    // R4 event beats simultaneous clear
    pulse_evt(5'b00011);
    @(negedge clk_i); evt_i = 5'b00001; wr_en_i = 1'b1; addr_i = 8'h00; wdata_i = 32'h3;
    @(negedge clk_i); evt_i = '0; wr_en_i = 1'b0;
    do_read(8'h00, 32'h00000001, "R4 event wins");

    // R10 unmapped and misaligned offsets
    do_write(8'h05, 32'h0);
    do_read(8'h04, 32'h0000001F, "R10 misaligned wr");
    do_write(8'h1C, 32'hFFFFFFFF);
    do_write(8'h40, 32'hFFFFFFFF);
    do_read(8'h1C, 32'h0, "R10 unmapped rd");
    do_read(8'h06, 32'h0, "R10 misaligned rd");
    chk("R10 ptr untouched", 32'(start_addr_o), 32'h000DE040);

    // R11 hold without read, and read-before-write
    written_addr_i = 20'h00040;
    repeat (3) @(negedge clk_i);
    chk("R11 hold", rdata_o, 32'h0);
    @(negedge clk_i); rd_en_i = 1'b1; wr_en_i = 1'b1; addr_i = 8'h04; wdata_i = 32'h2;
    @(negedge clk_i); rd_en_i = 1'b0; wr_en_i = 1'b0;
    chk("R11 read old", rdata_o, 32'h1F);

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      wr_en_i = ($urandom % 3) == 0;
      rd_en_i = ($urandom % 2) == 0;
      addr_i  = (($urandom % 8) == 0) ? 8'($urandom) : 8'(($urandom % 9) * 4);
      wdata_i = $urandom;
      evt_i   = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
      if (($urandom % 16) == 0) written_addr_i = AW'($urandom);
    end
    @(negedge clk_i); wr_en_i = 1'b0; rd_en_i = 1'b0; evt_i = '0;
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule